// File: doc/BRIEF.md
# Buffered SPI Master

This block is a serial peripheral bus master that exchanges 8-bit bytes with one attached device. It generates the serial clock itself, fixed in mode 0: the clock rests low, outgoing bits change on falling edges and incoming bits are captured on rising edges, with the most significant bit first. A one-byte holding stage on the transmit side and a one-byte result stage on the receive side sit in front of a single shift register. Because of these stages, the host can queue the next byte while the current one is on the wire, and bytes can flow back to back.

The host side uses two streams and a few plain control pins. Outgoing bytes enter through a valid/ready port. `tx_ready` is high only while the block is enabled and the holding stage is empty, and a byte is taken on any cycle where `tx_valid` and `tx_ready` are both high. Received bytes leave through a second valid/ready port. `rx_valid` stays high and `rx_data` is held until the host asserts `rx_ready`. If the host holds a byte back for longer than one transfer, the next received byte is discarded and a sticky overrun flag is set. An active-low select line can be driven around each transfer. A single interrupt line combines the transmit-empty and receive-full conditions.

The bit rate comes from a 3-bit prescaler and a 3-bit power-of-two selector. Together they give half an SCLK period of (presc+1)·2^rate bus cycles, which is an overall division of 2 to 2048.

Top module: `spi_mstr`

## Requirements
- R1: Mode 0 only: SCLK is low whenever no transfer runs. MOSI changes only while SCLK is low, and the first bit of a byte is already on MOSI when slave select falls, before the first rising edge. MISO is captured on rising SCLK edges.
- R2: Each transfer shifts 8 bits most-significant-bit first in both directions. The byte accepted on the transmit port appears on MOSI, and the byte seen on MISO is delivered on `rx_data`.
- R3: `tx_ready` equals enable AND holding-stage-empty. After a handshake, `tx_ready` is low in the next cycle. When the engine is idle, `tx_ready` returns high one cycle after that, because the byte moves into the shifter and the transfer starts.
- R4: `rx_valid` rises in the same cycle as the final falling SCLK edge of a byte. While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` do not change. A handshake empties the stage.
- R5: Half an SCLK period lasts (presc+1)·2^rate clock cycles, so a full SCLK period lasts twice that.
- R6: When `ss_oe` is 1, `ss_n` goes low in the cycle the transfer starts and stays low until its final falling SCLK edge. When `ss_oe` is 0, `ss_n` stays high.
- R7: If the holding stage is full when a byte ends, the next byte starts at once and `ss_n` is not released. Otherwise `ss_n` stays high for at least one full SCLK period before the next transfer.
- R8: A byte that completes while the result stage is full and not being read in that cycle is discarded. `rx_data` keeps the older byte and `overrun` is set. `overrun` stays set until a `stat_rd` pulse is followed by a later receive handshake.
- R9: `irq` is high exactly when (`txe_ie` and `tx_ready`) or (`rxf_ie` and `rx_valid`).
- R10: With `en` low, from the next cycle SCLK and MOSI are low, `ss_n` is high, `rx_valid` and `overrun` are cleared, and a queued transmit byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable; low aborts and clears |
| ss_oe | input | 1 | Drive slave select around transfers |
| txe_ie | input | 1 | Interrupt enable for transmit stage empty |
| rxf_ie | input | 1 | Interrupt enable for receive stage full |
| presc | input | 3 | Prescaler, divide by presc+1 |
| rate | input | 3 | Power-of-two selector, divide by 2^(rate+1) |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding stage can take a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Result stage holds a byte |
| rx_ready | input | 1 | Host takes the received byte |
| stat_rd | input | 1 | Status-read pulse, arms overrun clearing |
| overrun | output | 1 | Sticky receive overrun flag |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
Each result has a fixed latency from the edge that causes it. `tx_ready` falls one cycle after a handshake and comes back one cycle later with `ss_n` low. `rx_valid` and `overrun` change at the same edge as the eighth falling SCLK edge. SCLK rises (presc+1)·2^rate cycles after the select falls. A disabled engine shows idle pins one cycle after `en` drops. The bench drives inputs and samples outputs on falling clock edges. It waits on the bench-side slave's byte counter, which advances at the final SCLK fall, and then reads the block one half-cycle later, so every comparison lands on the first cycle its value is due. Rates and select gaps are measured by counting cycles between sampled edges.

// File: rtl/spi_mstr_pkg.sv
`timescale 1ns/1ps
package spi_mstr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_mstr_baud.sv
`timescale 1ns/1ps
// Half-period tick source: one tick every (presc+1)<<rate cycles while run is high.
module spi_mstr_baud #(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3,
  parameter int CNT_W  = PRE_W + (1 << RATE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRE_W-1:0]  presc,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] cnt;

  always_comb half_len = (CNT_W'(presc) + CNT_W'(1)) << rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || cnt == '0) cnt <= half_len - CNT_W'(1);
    else                        cnt <= cnt - CNT_W'(1);
  end

  assign tick = run && (cnt == '0);
endmodule

// File: rtl/spi_mstr_txbuf.sv
`timescale 1ns/1ps
// One-entry transmit holding stage with a valid/ready write side.
module spi_mstr_txbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  assign wr_ready = en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!en) begin
      full <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_mstr_rxbuf.sv
`timescale 1ns/1ps
// One-entry receive stage with sticky overrun, cleared by status read then data read.
module spi_mstr_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              put,
  input  logic [DATA_W-1:0] put_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_rd,
  output logic              overrun
);
  logic full;
  logic armed;
  logic pop;

  assign pop      = full && rd_ready;
  assign rd_valid = full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      rd_data <= '0;
      overrun <= 1'b0;
      armed   <= 1'b0;
    end else if (!en) begin
      full    <= 1'b0;
      overrun <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (stat_rd)  armed <= 1'b1;
      else if (pop) armed <= 1'b0;
      if (pop && armed) overrun <= 1'b0;
      if (put) begin
        if (!full || pop) begin
          full    <= 1'b1;
          rd_data <= put_data;
        end else begin
          overrun <= 1'b1;
        end
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_mstr_engine.sv
`timescale 1ns/1ps
// Mode-0 shift engine: loads from the holding stage, shifts MSB first, chains bytes.
module spi_mstr_engine
  import spi_mstr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PH_W   = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ss_oe,
  input  logic              tick,
  input  logic              tx_full,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              miso,
  output logic              load,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              run,
  output logic              sclk,
  output logic              mosi,
  output logic              ss_n
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(2 * DATA_W - 1);

  eng_state_e        state;
  logic [DATA_W-1:0] sh;
  logic [PH_W-1:0]   ph;
  logic              samp;

  always_comb begin
    load = 1'b0;
    done = 1'b0;
    if (en) begin
      unique case (state)
        ENG_IDLE:  load = tx_full;
        ENG_SHIFT: if (tick && ph == LAST_PH) begin
          done = 1'b1;
          load = tx_full;
        end
        default: ;
      endcase
    end
  end

  assign rx_byte = {sh[DATA_W-2:0], samp};
  assign run     = (state != ENG_IDLE);
  assign mosi    = (state == ENG_SHIFT) && sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      sh    <= '0;
      ph    <= '0;
      samp  <= 1'b0;
      sclk  <= 1'b0;
      ss_n  <= 1'b1;
    end else if (!en) begin
      state <= ENG_IDLE;
      ph    <= '0;
      sclk  <= 1'b0;
      ss_n  <= 1'b1;
    end else begin
      unique case (state)
        ENG_IDLE: if (tx_full) begin
          sh    <= tx_byte;
          ph    <= '0;
          ss_n  <= !ss_oe;
          state <= ENG_SHIFT;
        end
        ENG_SHIFT: if (tick) begin
          ph <= ph + 1'b1;
          if (!ph[0]) begin
            sclk <= 1'b1;
            samp <= miso;
          end else begin
            sclk <= 1'b0;
            sh   <= {sh[DATA_W-2:0], samp};
            if (ph == LAST_PH) begin
              ph <= '0;
              if (tx_full) begin
                sh <= tx_byte;
              end else begin
                state <= ENG_GAP;
                ss_n  <= 1'b1;
              end
            end
          end
        end
        ENG_GAP: if (tick) begin
          ph <= ph + 1'b1;
          if (ph[0]) begin
            ph    <= '0;
            state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_mstr.sv
`timescale 1ns/1ps
module spi_mstr #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ss_oe,
  input  logic              txe_ie,
  input  logic              rxf_ie,
  input  logic [PRE_W-1:0]  presc,
  input  logic [RATE_W-1:0] rate,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              stat_rd,
  output logic              overrun,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  localparam int CNT_W = PRE_W + (1 << RATE_W);

  logic              tick, run, load, done, hold_full;
  logic [DATA_W-1:0] hold_byte, shift_byte;

  spi_mstr_baud #(.PRE_W(PRE_W), .RATE_W(RATE_W), .CNT_W(CNT_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .presc(presc), .rate(rate), .tick(tick)
  );

  spi_mstr_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_valid(tx_valid), .wr_data(tx_data),
    .wr_ready(tx_ready), .take(load), .full(hold_full), .data(hold_byte)
  );

  spi_mstr_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_oe(ss_oe), .tick(tick),
    .tx_full(hold_full), .tx_byte(hold_byte), .miso(miso), .load(load),
    .done(done), .rx_byte(shift_byte), .run(run), .sclk(sclk), .mosi(mosi),
    .ss_n(ss_n)
  );

  spi_mstr_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .en(en), .put(done), .put_data(shift_byte),
    .rd_ready(rx_ready), .rd_valid(rx_valid), .rd_data(rx_data),
    .stat_rd(stat_rd), .overrun(overrun)
  );

  assign irq = (txe_ie && tx_ready) || (rxf_ie && rx_valid);
endmodule

// File: rtl/spi_mstr_chk.sv
`timescale 1ns/1ps
module spi_mstr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              overrun,
  input logic              sclk,
  input logic              mosi,
  input logic              ss_n
);
  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> (!sclk || $stable(mosi)));

  assert_tx_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && overrun && !(rx_valid && rx_ready)) |=> overrun);

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && ss_n && !rx_valid && !overrun));
endmodule

bind spi_mstr spi_mstr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .overrun(overrun), .sclk(sclk), .mosi(mosi), .ss_n(ss_n)
);

// File: tb/spi_mstr_bench.sv
`timescale 1ns/1ps
module spi_mstr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, ss_oe = 1'b1, txe_ie = 1'b0, rxf_ie = 1'b0;
  logic [2:0] presc = 3'd0, rate = 3'd0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, rx_ready = 1'b0, stat_rd = 1'b0;
  logic tx_ready, rx_valid, overrun, irq, sclk, mosi, miso, ss_n;
  logic [7:0] rx_data;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spi_mstr u_spi_mstr (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_oe(ss_oe), .txe_ie(txe_ie),
    .rxf_ie(rxf_ie), .presc(presc), .rate(rate), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .stat_rd(stat_rd),
    .overrun(overrun), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n)
  );

  // Bench-side slave: byte k answers 8'h3C + k*8'h11, logs what arrives on MOSI.
  logic [7:0] sl_cur = 8'h3C, sl_sh = 8'h3C, mcap = 8'h00;
  logic [7:0] mosi_log [32];
  int sbit = 0, mbit = 0, slv_bytes = 0;
  assign miso = sl_sh[7];

  always @(posedge sclk) begin
    mcap = {mcap[6:0], mosi};
    mbit++;
    if (mbit == 8) begin
      mosi_log[slv_bytes & 31] = mcap;
      mbit = 0;
    end
  end

  always @(negedge sclk) begin
    sbit++;
    if (sbit == 8) begin
      sl_cur = sl_cur + 8'h11;
      sl_sh  = sl_cur;
      sbit   = 0;
      slv_bytes++;
    end else begin
      sl_sh = sl_sh << 1;
    end
  end

  // Monitors sampled on falling clock edges.
  logic sclk_q = 1'b0, ss_q = 1'b1;
  int last_rise = 0, last_per = 0, hi_run = 0, last_gap = 0, ss_rises = 0, ss_low = 0;
  always @(negedge clk) begin
    cyc++;
    if (sclk && !sclk_q) begin
      last_per  = cyc - last_rise;
      last_rise = cyc;
    end
    if (ss_n && !ss_q) ss_rises++;
    if (!ss_n) ss_low++;
    if (ss_n) hi_run++;
    else if (hi_run != 0) begin
      last_gap = hi_run;
      hi_run   = 0;
    end
    sclk_q = sclk;
    ss_q   = ss_n;
  end

  function automatic logic [7:0] slave_byte(input int k);
    return 8'h3C + 8'(k) * 8'h11;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    int guard = 0;
    while (slv_bytes < n && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic read_rx();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    check(!tx_ready && !rx_valid && !irq && !overrun, "R10 reset", {tx_ready, rx_valid, irq, overrun}, 0);
    check(!sclk && ss_n && !mosi, "R1 reset idle pins", {sclk, ss_n, mosi}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    check(tx_ready, "R3 ready when enabled", tx_ready, 1);
  endtask

  task automatic t_single();
    int base = slv_bytes;
    presc = 3'd0; rate = 3'd0;
    @(negedge clk);
    tx_data = 8'hA5; tx_valid = 1'b1;
    @(negedge clk) tx_valid = 1'b0;
    check(!tx_ready, "R3 ready drops after handshake", tx_ready, 0);
    @(negedge clk);
    check(tx_ready && !ss_n, "R3 R6 load and select", {tx_ready, ss_n}, 2'b10);
    check(mosi == 1'b1 && !sclk, "R1 first bit before first rise", {mosi, sclk}, 2'b10);
    wait_bytes(base + 1);
    check(rx_valid && !sclk, "R4 rx valid at last fall", {rx_valid, sclk}, 2'b10);
    check(rx_data == slave_byte(base), "R2 MISO byte", rx_data, slave_byte(base));
    check(mosi_log[base & 31] == 8'hA5, "R2 MOSI byte", mosi_log[base & 31], 8'hA5);
    check(ss_n, "R6 select released", ss_n, 1);
    read_rx();
    check(!rx_valid, "R4 handshake empties", rx_valid, 0);
  endtask

  task automatic t_rate();
    int base = slv_bytes;
    presc = 3'd2; rate = 3'd1;
    send(8'h5A);
    wait_bytes(base + 1);
    check(last_per == 12, "R5 period presc2 rate1", last_per, 12);
    read_rx();
    presc = 3'd0; rate = 3'd2;
    send(8'hC3);
    wait_bytes(base + 2);
    check(last_per == 8, "R5 period presc0 rate2", last_per, 8);
    check(rx_data == slave_byte(base + 1), "R2 second rate byte", rx_data, slave_byte(base + 1));
    read_rx();
  endtask

  task automatic t_stream();
    int base = slv_bytes;
    int rises0;
    presc = 3'd0; rate = 3'd1;
    repeat (10) @(negedge clk);
    rises0 = ss_rises;
    send(8'h96);
    send(8'h3B);
    wait_bytes(base + 1);
    check(rx_data == slave_byte(base), "R4 stream byte 0", rx_data, slave_byte(base));
    check(!ss_n, "R7 select held between bytes", ss_n, 0);
    read_rx();
    wait_bytes(base + 2);
    @(negedge clk);
    check(ss_rises - rises0 == 1, "R7 one release for two bytes", ss_rises - rises0, 1);
    check(mosi_log[(base + 1) & 31] == 8'h3B, "R2 stream MOSI byte 1", mosi_log[(base + 1) & 31], 8'h3B);
    check(rx_data == slave_byte(base + 1), "R4 stream byte 1", rx_data, slave_byte(base + 1));
    read_rx();
    send(8'h77);
    wait_bytes(base + 3);
    check(last_gap >= 4, "R7 gap at least one period", last_gap, 4);
    read_rx();
  endtask

  task automatic t_overrun();
    int base = slv_bytes;
    presc = 3'd0; rate = 3'd0;
    send(8'h01);
    send(8'h02);
    wait_bytes(base + 2);
    check(overrun, "R8 overrun set", overrun, 1);
    check(rx_data == slave_byte(base), "R8 old byte kept", rx_data, slave_byte(base));
    read_rx();
    check(!rx_valid && overrun, "R8 read alone keeps flag", {rx_valid, overrun}, 2'b01);
    send(8'h03);
    wait_bytes(base + 3);
    check(rx_data == slave_byte(base + 2), "R2 byte after overrun", rx_data, slave_byte(base + 2));
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    read_rx();
    check(!overrun && !rx_valid, "R8 status then data clears", {overrun, rx_valid}, 0);
  endtask

  task automatic t_irq();
    int base = slv_bytes;
    txe_ie = 1'b1; rxf_ie = 1'b0;
    @(negedge clk);
    check(irq, "R9 tx empty irq", irq, 1);
    txe_ie = 1'b0;
    @(negedge clk);
    check(!irq, "R9 masked", irq, 0);
    send(8'h44);
    wait_bytes(base + 1);
    rxf_ie = 1'b1;
    @(negedge clk);
    check(irq, "R9 rx full irq", irq, 1);
    read_rx();
    check(!irq, "R9 rx irq clears", irq, 0);
    rxf_ie = 1'b0;
  endtask

  task automatic t_no_ss();
    int base = slv_bytes;
    int low0;
    ss_oe = 1'b0;
    @(negedge clk);
    low0 = ss_low;
    send(8'hE1);
    wait_bytes(base + 1);
    check(ss_low == low0, "R6 select off stays high", ss_low - low0, 0);
    check(rx_data == slave_byte(base), "R2 byte without select", rx_data, slave_byte(base));
    read_rx();
    ss_oe = 1'b1;
  endtask

  task automatic t_disable();
    presc = 3'd7; rate = 3'd3;
    send(8'hF0);
    send(8'h0F);
    repeat (100) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!sclk && ss_n && !mosi, "R10 pins idle", {sclk, ss_n, mosi}, 3'b010);
    check(!tx_ready && !rx_valid, "R10 flags cleared", {tx_ready, rx_valid}, 0);
    en = 1'b1;
    @(negedge clk);
    check(tx_ready, "R10 queued byte dropped", tx_ready, 1);
    repeat (20) @(negedge clk);
    check(ss_n && !sclk, "R10 no transfer restarts", {ss_n, sclk}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_rate();
    t_stream();
    t_overrun();
    t_irq();
    t_no_ss();
    t_disable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule